// File: doc/BRIEF.md
# Extended-Data-Out DQ Drive Enable Controller

This block decides, cycle by cycle, whether the DQ bus of an extended-data-out DRAM is driven. All strobes are active low and sampled on the system clock. A read captured while the row and column strobes are both low keeps the bus driven after the column strobe rises, so a page-mode controller can precharge the column strobe without losing the output data.

Only a few conditions end that hold. The output-enable pin gates the bus directly. A latched disable is entered through either of two output-enable patterns while the column strobe is high, and it stays in force until the column strobe falls again. Two turn-off timers end the held data: one runs while both strobes are high, the other while write enable is low. All hold times, pulse widths and delays are counted in clock cycles and set by parameters.

Top module: `edo_dq_enable`

## Requirements
- R1: A sampled cycle with `row_n`=0, `col_n`=0, `wr_n`=1 and `rd_valid`=1 captures read data; with `oe_n`=0 in that cycle `dq_drive` is 1 after that clock edge. Without such a capture `dq_drive` stays 0. During reset and in the cycle after it `dq_drive` is 0.
- R2: Once read data is held, `dq_drive` stays 1 after `col_n` rises for as long as `oe_n` stays low and neither timer of R7 or R8 has expired.
- R3: Any cycle sampled with `oe_n`=1 gives `dq_drive`=0 after that edge; with the column strobe low, returning `oe_n` to 0 drives the held data again.
- R4: If `oe_n` is 1 in the cycle where `col_n` is first sampled high and stays 1 for `HOLD_CYC` consecutive cycles, the outputs latch disabled: `dq_drive` stays 0 whatever `oe_n` does until `col_n` falls. A shorter run does not latch.
- R5: If `oe_n` is 0 at the column-strobe rise but later goes high for `PULSE_CYC` consecutive cycles while `col_n` stays high, the outputs latch disabled as in R4. A shorter pulse does not latch.
- R6: A falling edge of `col_n` clears the latched disable in the same cycle, so a read captured in that cycle drives the bus after that edge.
- R7: After `row_n` and `col_n` have both been sampled high for `REL_DLY_CYC` consecutive cycles the held data is dropped and `dq_drive` is 0 after that edge.
- R8: After `wr_n` has been sampled low for `WE_DLY_CYC` consecutive cycles the held data is dropped and `dq_drive` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_n | input | 1 | Sampled row strobe, active low |
| col_n | input | 1 | Internal column strobe (earliest byte strobe low), active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| rd_valid | input | 1 | Array read data valid for the current column |
| dq_drive | output | 1 | Tri-state drive enable for the DQ bus |

## Verification
The bench builds the block with `HOLD_CYC`=2, `PULSE_CYC`=3, `REL_DLY_CYC`=2 and `WE_DLY_CYC`=3. These small and unequal values make each threshold reachable in a handful of cycles, so every latch and turn-off path is exercised both one cycle short of its limit and exactly at it. Because the hold and pulse limits differ, the bench can tell a run that began at the column-strobe rise from one that began later.

// File: rtl/edo_pkg.sv
// Shared helpers for the EDO DQ drive-enable block.
// Assumes all parameters are positive cycle counts.
package edo_pkg;

    // Width of a counter that must hold values 0..limit.
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    // Larger of two cycle limits.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_strobe_edge.sv
// Column-strobe edge detector.
// Registers the sampled column strobe and reports rise and fall edges
// relative to the previous sample. The idle state after reset is high.
module edo_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic col_n,
    output logic col_rise,
    output logic col_fall
);
    logic col_q;

    // Remember the last sampled strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= 1'b1;
        else        col_q <= col_n;
    end

    // Edge flags for the current sample.
    always_comb begin
        col_rise = !col_q && col_n;
        col_fall = col_q && !col_n;
    end
endmodule

// File: rtl/edo_run_timer.sv
// Consecutive-cycle run timer.
// Counts cycles with run high; expire is high in the LIM-th consecutive
// run cycle and each following run cycle. Any cycle with run low restarts it.
// Assumes LIM >= 1.
module edo_run_timer #(
    parameter int LIM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    import edo_pkg::*;
    localparam int CW = cnt_width(LIM);
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] cnt_q;

    // Expiry once LIM-1 earlier run cycles have been seen.
    always_comb expire = run && (cnt_q == LAST);

    // Count run cycles, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!run)      cnt_q <= '0;
        else if (!expire)   cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/edo_oe_latch.sv
// Latched output-disable tracker.
// While the column strobe is high, counts consecutive output-enable-high
// cycles. A run starting in the rise cycle needs HOLD_CYC cycles, a run
// starting later needs PULSE_CYC cycles. Reaching the limit sets the latch;
// a column-strobe fall clears it. Assumes both limits are >= 1.
module edo_oe_latch #(
    parameter int HOLD_CYC  = 2,
    parameter int PULSE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_n,
    input  logic col_rise,
    input  logic col_fall,
    input  logic oe_n,
    output logic lat_d,
    output logic lat_q
);
    import edo_pkg::*;
    localparam int MAXT = max2(HOLD_CYC, PULSE_CYC);
    localparam int CW   = cnt_width(MAXT);

    logic [CW-1:0] cnt_q;
    logic          from_rise_q;
    logic          from_rise_now;
    logic          counting;
    logic [CW:0]   thr;
    logic          hit;

    // Pick the threshold that applies to the current run.
    always_comb begin
        counting      = col_n && oe_n;
        from_rise_now = (cnt_q == '0) ? col_rise : from_rise_q;
        thr           = from_rise_now ? (CW+1)'(HOLD_CYC) : (CW+1)'(PULSE_CYC);
        hit           = counting && (({1'b0, cnt_q} + 1'b1) >= thr);
    end

    // Next latch value: fall clears first, then a completed run sets.
    always_comb begin
        if (col_fall) lat_d = 1'b0;
        else if (hit) lat_d = 1'b1;
        else          lat_d = lat_q;
    end

    // Run counter and its origin flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !counting) begin
            cnt_q       <= '0;
            from_rise_q <= 1'b0;
        end else begin
            from_rise_q <= from_rise_now;
            if (cnt_q != CW'(MAXT)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= 1'b0;
        else        lat_q <= lat_d;
    end

    p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && col_n) |=> lat_q);
    p_fall_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_fall |=> !lat_q);
    p_set_only_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q) |-> $past(col_n));
endmodule

// File: rtl/edo_dq_enable.sv
// EDO DQ drive-enable controller (top).
// Holds captured read data across column-strobe precharge and drives the
// DQ bus while output enable is low and no latched disable is in force.
// Held data is dropped by the strobe-release timer or the write timer.
// Inputs are assumed synchronous to clk; the output is registered.
module edo_dq_enable #(
    parameter int HOLD_CYC    = 2,
    parameter int PULSE_CYC   = 3,
    parameter int REL_DLY_CYC = 2,
    parameter int WE_DLY_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_n,
    input  logic col_n,
    input  logic oe_n,
    input  logic wr_n,
    input  logic rd_valid,
    output logic dq_drive
);
    logic col_rise, col_fall;
    logic lat_d, lat_q;
    logic rel_exp, we_exp;
    logic capture;
    logic held_q, held_d;
    logic drive_d;

    edo_strobe_edge i_edge (
        .clk(clk), .rst_n(rst_n), .col_n(col_n),
        .col_rise(col_rise), .col_fall(col_fall)
    );

    edo_oe_latch #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) i_latch (
        .clk(clk), .rst_n(rst_n), .col_n(col_n),
        .col_rise(col_rise), .col_fall(col_fall), .oe_n(oe_n),
        .lat_d(lat_d), .lat_q(lat_q)
    );

    edo_run_timer #(.LIM(REL_DLY_CYC)) i_rel_timer (
        .clk(clk), .rst_n(rst_n), .run(row_n && col_n), .expire(rel_exp)
    );

    edo_run_timer #(.LIM(WE_DLY_CYC)) i_we_timer (
        .clk(clk), .rst_n(rst_n), .run(!wr_n), .expire(we_exp)
    );

    // Held-data state: timers drop it, a read access captures it.
    always_comb begin
        capture = !row_n && !col_n && wr_n && rd_valid;
        if (rel_exp || we_exp) held_d = 1'b0;
        else if (capture)      held_d = 1'b1;
        else                   held_d = held_q;
        drive_d = held_d && !oe_n && !lat_d;
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= 1'b0;
            dq_drive <= 1'b0;
        end else begin
            held_q   <= held_d;
            dq_drive <= drive_d;
        end
    end

    p_oe_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dq_drive);
    p_release_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_exp |=> !dq_drive);
    p_write_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_exp |=> !dq_drive);
    p_latch_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q |-> !dq_drive);
    p_drive_needs_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> held_q);
endmodule

// File: tb/test_edo_dq_enable.sv
// Directed sweep of the DQ drive-enable controller with small limits.
module test_edo_dq_enable;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_n = 1'b1, col_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1, rd_valid = 1'b0;
    logic dq_drive;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edo_dq_enable #(.HOLD_CYC(2), .PULSE_CYC(3), .REL_DLY_CYC(2), .WE_DLY_CYC(3))
    i_edo_dq_enable (
        .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
        .oe_n(oe_n), .wr_n(wr_n), .rd_valid(rd_valid), .dq_drive(dq_drive)
    );

    // Apply one cycle of inputs and let the edge sample them.
    task automatic cyc(input logic r, input logic c, input logic o,
                       input logic w, input logic v);
        @(negedge clk);
        row_n = r; col_n = c; oe_n = o; wr_n = w; rd_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (dq_drive !== exp) begin
            fails++;
            $display("FAIL %s dq_drive=%b expected=%b at %0t", req, dq_drive, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(1,1,1,1,0); chk(0, "R1 reset");
        @(negedge clk); rst_n = 1'b1;
        cyc(1,1,0,1,0); chk(0, "R1 after reset");
        // R1: strobes low but no valid data -> no drive
        cyc(0,1,0,1,0); chk(0, "R1 row only");
        cyc(0,0,0,1,0); chk(0, "R1 no rd_valid");
        // R1: read capture drives
        cyc(0,0,0,1,1); chk(1, "R1 read");
        // R2: EDO hold across column precharge
        cyc(0,1,0,1,0); chk(1, "R2 hold rise");
        cyc(0,1,0,1,0); chk(1, "R2 hold");
        cyc(0,1,0,1,0); chk(1, "R2 hold");
        // R3: OE toggling with both strobes low
        cyc(0,0,0,1,1); chk(1, "R3 read");
        cyc(0,0,1,1,1); chk(0, "R3 oe high");
        cyc(0,0,0,1,1); chk(1, "R3 oe low again");
        cyc(0,0,1,1,1); chk(0, "R3 oe high");
        cyc(0,0,1,1,1); chk(0, "R3 oe high longer, no latch while col low");
        cyc(0,0,0,1,1); chk(1, "R3 drive resumes");
        // R4: OE high at rise for one cycle only -> no latch
        cyc(0,1,1,1,0); chk(0, "R4 short run oe high");
        cyc(0,1,0,1,0); chk(1, "R4 short run no latch");
        // R4: OE high at rise for HOLD_CYC=2 -> latch
        cyc(0,0,0,1,1); chk(1, "R4 read");
        cyc(0,1,1,1,0); chk(0, "R4 rise oe high");
        cyc(0,1,1,1,0); chk(0, "R4 hold met");
        cyc(0,1,0,1,0); chk(0, "R4 latched ignores oe");
        cyc(0,1,0,1,0); chk(0, "R4 latched");
        cyc(0,1,1,1,0); chk(0, "R4 latched");
        cyc(0,1,0,1,0); chk(0, "R4 latched");
        // R6: column fall clears the latch
        cyc(0,0,0,1,1); chk(1, "R6 fall clears");
        // R5: pulse after rise, 2 cycles (< PULSE_CYC) -> no latch
        cyc(0,1,0,1,0); chk(1, "R5 rise oe low");
        cyc(0,1,1,1,0); chk(0, "R5 pulse");
        cyc(0,1,1,1,0); chk(0, "R5 pulse");
        cyc(0,1,0,1,0); chk(1, "R5 short pulse no latch");
        // R5: pulse of exactly 3 -> latch
        cyc(0,1,1,1,0); chk(0, "R5 pulse");
        cyc(0,1,1,1,0); chk(0, "R5 pulse");
        cyc(0,1,1,1,0); chk(0, "R5 pulse");
        cyc(0,1,0,1,0); chk(0, "R5 latched");
        cyc(0,1,0,1,0); chk(0, "R5 latched");
        // R6: fall without read -> data still held, latch cleared
        cyc(0,0,0,1,0); chk(1, "R6 fall clears, data held");
        // R7: release of both strobes
        cyc(0,1,0,1,0); chk(1, "R7 col high");
        cyc(1,1,0,1,0); chk(1, "R7 both high 1");
        cyc(1,1,0,1,0); chk(0, "R7 both high 2");
        cyc(1,1,0,1,0); chk(0, "R7 stays off");
        // R7: row high with col low does not release
        cyc(0,0,0,1,1); chk(1, "R7 read");
        cyc(1,0,0,1,0); chk(1, "R7 row high col low");
        cyc(1,0,0,1,0); chk(1, "R7 row high col low");
        cyc(1,1,0,1,0); chk(1, "R7 one both-high cycle");
        cyc(0,0,0,1,1); chk(1, "R7 read again");
        // R8: write enable low timer
        cyc(0,0,0,0,0); chk(1, "R8 we low 1");
        cyc(0,0,0,0,0); chk(1, "R8 we low 2");
        cyc(0,0,0,0,0); chk(0, "R8 we low 3");
        cyc(0,0,0,1,0); chk(0, "R8 data dropped");
        // R8: short write-enable pulse keeps data
        cyc(0,0,0,1,1); chk(1, "R8 read");
        cyc(0,0,0,0,0); chk(1, "R8 short 1");
        cyc(0,0,0,0,0); chk(1, "R8 short 2");
        cyc(0,0,0,1,0); chk(1, "R8 short pulse keeps data");
        cyc(1,1,1,1,0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule